// File: doc/BRIEF.md
# Byte-wide configuration stream loader

This block accepts a configuration stream one whole byte per rising edge of an external configuration clock, instead of one bit per edge. At a 10 MHz clock that is the same throughput as an 80 Mb/s serial stream. A state machine first checks a fixed seven-byte header. It then collects a fixed number of data frames. Each frame must open with a start byte and close with a check byte. There is no length count and no CRC. The loader knows it is complete only when it has filled its own fixed frame budget. It then needs a short run of don't-care start-up clocks before it signals completion.

Several loaders can share one byte bus and one clock. Each loader's chain-status output feeds the chip-select input of the next loader. Every loader takes in the header at the same time. After that, only the loader whose chip-select is high accepts frames. When a loader is full, it raises its status output and so hands the bus to the next loader. A wrong header, start or check byte freezes the loader and pulls its error flag low. Only a low pulse on the program input clears it.

States: `ST_IDLE` (waiting for the load mode), `ST_HDR` (header bytes), `ST_FSTART` (expecting a frame start byte), `ST_FDATA` (frame data bytes), `ST_FCHECK` (expecting the frame check byte), `ST_FULL` (start-up clocks), `ST_DONE` (complete) and `ST_ERR` (error, frozen).

Transitions:
- IDLE→HDR: on an edge with the load mode selected.
- HDR→HDR: on a good header byte.
- HDR→FSTART: on the seventh good header byte.
- HDR→ERR: on a bad header byte.
- FSTART→FDATA: on a start byte while selected.
- FSTART→ERR: on any other byte while selected.
- FDATA→FCHECK: after the last data byte of a frame.
- FCHECK→FSTART: on a good check byte for a frame that is not the last.
- FCHECK→FULL: on a good check byte for the last frame.
- FCHECK→ERR: on a bad check byte.
- FULL→DONE: after the start-up clocks have all passed.
- DONE and ERR hold their state until the program input goes low.

Top module: `bytecfg_loader`

## Requirements
- R1: The loader leaves `ST_IDLE` only on an edge where `mode_sel` is 3'b010. While `mode_sel` has any other value, bytes are ignored: `chain_out` and `init_n` stay high and `frame_valid` stays low.
- R2: The edge that leaves `ST_IDLE` takes no byte. The seven header bytes are taken on the next seven consecutive edges, whatever the value of `cs_in`.
- R3: Bit `data_in[0]` carries the first-listed bit D0. The expected header values, in order, are 8'hFF, 8'hFF, 8'h4F (preamble), 8'hFF, 8'hFF, 8'hFF, 8'h4B (end-of-header check). A header byte with any other value sends the loader to the error state.
- R4: `chain_out` is high from reset until the edge that takes the seventh header byte. From that edge it is low, until the edge that takes the last frame's check byte.
- R5: A frame is the start byte 8'h7F, then FRAME_BYTES data bytes, then the check byte 8'h4B. Frame bytes are taken only on edges where `cs_in` is high. Each data byte appears on `frame_byte`, with `frame_valid` high for one cycle, right after the edge that took it.
- R6: A wrong start byte or a wrong check byte drives `init_n` low. It stays low until `prog_n` goes low. After that point no further `frame_valid` appears and `done` never rises.
- R7: After NUM_FRAMES frames, `chain_out` goes high. All later bytes are ignored and raise no error.
- R8: `done` rises exactly STARTUP_CYCLES edges after the edge that filled the loader. It then stays high while `chain_out` stays high.
- R9: While `prog_n` is low, the loader is held in `ST_IDLE`, with `chain_out` high, `init_n` high, `done` low and `frame_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock; one byte is taken per rising edge |
| prog_n | input | 1 | Program input, active low; asynchronously restarts the loader |
| mode_sel | input | 3 | Mode pins; 3'b010 selects byte-wide loading |
| cs_in | input | 1 | Chip-select in, fed by the previous loader's `chain_out` |
| data_in | input | 8 | Shared configuration byte bus; bit 0 is D0 |
| frame_byte | output | 8 | Last accepted frame data byte |
| frame_valid | output | 1 | One-cycle strobe marking a new `frame_byte` |
| chain_out | output | 1 | Chain status; high enables the next loader |
| init_n | output | 1 | Error flag, open-drain style; low after a failed check |
| done | output | 1 | Completion, open-drain style; high after the start-up clocks |

## Verification
Some rules can be checked on every cycle, and assertions cover those:
- the error flag and completion are sticky;
- completion never coexists with an error;
- a data strobe follows only a selected edge;
- a strobe never appears while the chain output is high.

Other behaviour needs a whole scenario, and only the bench's scenarios can show it:
- the exact edge on which the chain output falls and rises;
- the start-up count before completion;
- the handoff between two loaders on one bus;
- rejection of a corrupted header or check byte;
- the mode gate.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;

    localparam int          HDR_LEN   = 7;
    localparam logic [7:0]  FILL_BYTE = 8'hFF;
    localparam logic [7:0]  PREAMBLE  = 8'h4F;
    localparam logic [7:0]  CHECK_BYTE = 8'h4B;
    localparam logic [7:0]  START_BYTE = 8'h7F;
    localparam logic [2:0]  LOAD_MODE = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_FSTART,
        ST_FDATA,
        ST_FCHECK,
        ST_FULL,
        ST_DONE,
        ST_ERR
    } ldr_state_t;

    // expected header byte at a given position (bit 0 is D0)
    function automatic logic [7:0] hdr_byte(input logic [2:0] pos);
        logic [7:0] b;
        case (pos)
            3'd2:    b = PREAMBLE;
            3'd6:    b = CHECK_BYTE;
            default: b = FILL_BYTE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cfgld_cnt.sv
`timescale 1ns/1ps
module cfgld_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic last
);
    generate
        if (LIMIT <= 1) begin : g_single
            assign last = 1'b1;
        end else begin : g_multi
            localparam int W = $clog2(LIMIT);
            localparam logic [W-1:0] TOP = W'(LIMIT - 1);
            logic [W-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (step) begin
                    cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
                end
            end

            assign last = (cnt == TOP);
        end
    endgenerate
endmodule

// File: rtl/cfgld_hdr_check.sv
`timescale 1ns/1ps
module cfgld_hdr_check
    import cfgld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic [7:0] data_in,
    output logic       hdr_ok,
    output logic       hdr_last
);
    localparam logic [2:0] LAST_POS = 3'(HDR_LEN - 1);

    logic [2:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        end
    end

    assign hdr_ok   = (data_in == hdr_byte(pos));
    assign hdr_last = (pos == LAST_POS);
endmodule

// File: rtl/cfgld_frame_out.sv
`timescale 1ns/1ps
module cfgld_frame_out #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] byte_in,
    output logic [DW-1:0] frame_byte,
    output logic          frame_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_byte  <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= take;
            if (take) begin
                frame_byte <= byte_in;
            end
        end
    end
endmodule

// File: rtl/cfgld_fsm.sv
`timescale 1ns/1ps
module cfgld_fsm
    import cfgld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_ok,
    input  logic       cs_in,
    input  logic [7:0] data_in,
    input  logic       hdr_ok,
    input  logic       hdr_last,
    input  logic       byte_last,
    input  logic       frame_last,
    input  logic       su_last,
    output logic       hdr_step,
    output logic       data_step,
    output logic       frame_step,
    output logic       su_step,
    output logic       chain_out,
    output logic       init_n,
    output logic       done
);
    ldr_state_t state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions and counter steps
    always_comb begin
        nxt        = state;
        hdr_step   = 1'b0;
        data_step  = 1'b0;
        frame_step = 1'b0;
        su_step    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (mode_ok) nxt = ST_HDR;
            end
            ST_HDR: begin
                hdr_step = 1'b1;
                if (!hdr_ok)       nxt = ST_ERR;
                else if (hdr_last) nxt = ST_FSTART;
            end
            ST_FSTART: begin
                if (cs_in) nxt = (data_in == START_BYTE) ? ST_FDATA : ST_ERR;
            end
            ST_FDATA: begin
                if (cs_in) begin
                    data_step = 1'b1;
                    if (byte_last) nxt = ST_FCHECK;
                end
            end
            ST_FCHECK: begin
                if (cs_in) begin
                    if (data_in == CHECK_BYTE) begin
                        frame_step = 1'b1;
                        nxt = frame_last ? ST_FULL : ST_FSTART;
                    end else begin
                        nxt = ST_ERR;
                    end
                end
            end
            ST_FULL: begin
                su_step = 1'b1;
                if (su_last) nxt = ST_DONE;
            end
            ST_DONE: begin
                nxt = ST_DONE;
            end
            ST_ERR: begin
                nxt = ST_ERR;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        chain_out = 1'b0;
        init_n    = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE, ST_HDR: chain_out = 1'b1;
            ST_FSTART, ST_FDATA, ST_FCHECK: chain_out = 1'b0;
            ST_FULL:   chain_out = 1'b1;
            ST_DONE: begin
                chain_out = 1'b1;
                done      = 1'b1;
            end
            ST_ERR:    init_n = 1'b0;
            default:   chain_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/bytecfg_loader.sv
`timescale 1ns/1ps
module bytecfg_loader
    import cfgld_pkg::*;
#(
    parameter int FRAME_BYTES    = 4,
    parameter int NUM_FRAMES     = 2,
    parameter int STARTUP_CYCLES = 6
) (
    input  logic       cfg_clk,
    input  logic       prog_n,
    input  logic [2:0] mode_sel,
    input  logic       cs_in,
    input  logic [7:0] data_in,
    output logic [7:0] frame_byte,
    output logic       frame_valid,
    output logic       chain_out,
    output logic       init_n,
    output logic       done
);
    logic mode_ok;
    logic hdr_ok, hdr_last, byte_last, frame_last, su_last;
    logic hdr_step, data_step, frame_step, su_step;

    assign mode_ok = (mode_sel == LOAD_MODE);

    cfgld_hdr_check hdr_i (
        .clk      (cfg_clk),
        .rst_n    (prog_n),
        .step     (hdr_step),
        .data_in  (data_in),
        .hdr_ok   (hdr_ok),
        .hdr_last (hdr_last)
    );

    cfgld_cnt #(.LIMIT(FRAME_BYTES)) byte_cnt_i (
        .clk   (cfg_clk),
        .rst_n (prog_n),
        .step  (data_step),
        .last  (byte_last)
    );

    cfgld_cnt #(.LIMIT(NUM_FRAMES)) frame_cnt_i (
        .clk   (cfg_clk),
        .rst_n (prog_n),
        .step  (frame_step),
        .last  (frame_last)
    );

    cfgld_cnt #(.LIMIT(STARTUP_CYCLES)) su_cnt_i (
        .clk   (cfg_clk),
        .rst_n (prog_n),
        .step  (su_step),
        .last  (su_last)
    );

    cfgld_fsm fsm_i (
        .clk        (cfg_clk),
        .rst_n      (prog_n),
        .mode_ok    (mode_ok),
        .cs_in      (cs_in),
        .data_in    (data_in),
        .hdr_ok     (hdr_ok),
        .hdr_last   (hdr_last),
        .byte_last  (byte_last),
        .frame_last (frame_last),
        .su_last    (su_last),
        .hdr_step   (hdr_step),
        .data_step  (data_step),
        .frame_step (frame_step),
        .su_step    (su_step),
        .chain_out  (chain_out),
        .init_n     (init_n),
        .done       (done)
    );

    cfgld_frame_out #(.DW(8)) out_i (
        .clk         (cfg_clk),
        .rst_n       (prog_n),
        .take        (data_step),
        .byte_in     (data_in),
        .frame_byte  (frame_byte),
        .frame_valid (frame_valid)
    );
endmodule

// File: rtl/cfgld_chk.sv
`timescale 1ns/1ps
module cfgld_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_in,
    input logic frame_valid,
    input logic chain_out,
    input logic init_n,
    input logic done
);
    // R6: error flag holds until program pulse
    assert_init_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |=> !init_n);

    // R6: no data strobe while in error
    assert_no_data_in_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> !frame_valid);

    // R8: completion holds
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8: completion only with chain released and no error
    assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chain_out && init_n));

    // R5: a data strobe follows only a selected edge
    assert_valid_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(cs_in));

    // R4: no frame data while the chain output is high
    assert_no_data_when_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out |-> !frame_valid);
endmodule

bind bytecfg_loader cfgld_chk chk_i (
    .clk         (cfg_clk),
    .rst_n       (prog_n),
    .cs_in       (cs_in),
    .frame_valid (frame_valid),
    .chain_out   (chain_out),
    .init_n      (init_n),
    .done        (done)
);

// File: tb/bytecfg_loader_tb_top.sv
`timescale 1ns/1ps
module bytecfg_loader_tb_top;
    localparam int FB  = 4;
    localparam int NF  = 2;
    localparam int SU  = 6;
    localparam int FL  = FB + 2;
    localparam int DEVF   = NF * FL;
    localparam int A_BASE = 8;
    localparam int A_END  = A_BASE + DEVF - 1;
    localparam int B_BASE = A_END + 1;
    localparam int B_END  = B_BASE + DEVF - 1;
    localparam int NV     = B_END + SU + 1;

    typedef logic [13:0] vec_t;
    typedef vec_t vec_arr_t [NV];

    function automatic logic [7:0] hdr_val(input int i);
        case (i)
            2: return 8'h4F;
            6: return 8'h4B;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] frame_val(input int e, input int base);
        int off = (e - base) % FL;
        if (off == 0) return 8'h7F;
        if (off == FL - 1) return 8'h4B;
        return 8'((e * 13 + 5) & 255);
    endfunction

    // {byte, chain_a, chain_b, done_a, done_b, valid_a, valid_b}
    function automatic vec_arr_t build_vec();
        vec_arr_t v;
        for (int e = 0; e < NV; e++) begin
            logic [7:0] b;
            logic ca, cb, da, db, va, vb;
            if (e == 0) b = 8'h00;
            else if (e <= 7) b = hdr_val(e - 1);
            else if (e <= A_END) b = frame_val(e, A_BASE);
            else if (e <= B_END) b = frame_val(e, B_BASE);
            else b = 8'hFF;
            ca = (e < 7) || (e >= A_END);
            cb = (e < 7) || (e >= B_END);
            da = (e >= A_END + SU);
            db = (e >= B_END + SU);
            va = (e >= A_BASE) && (e <= A_END) &&
                 (((e - A_BASE) % FL) >= 1) && (((e - A_BASE) % FL) <= FB);
            vb = (e >= B_BASE) && (e <= B_END) &&
                 (((e - B_BASE) % FL) >= 1) && (((e - B_BASE) % FL) <= FB);
            v[e] = {b, ca, cb, da, db, va, vb};
        end
        return v;
    endfunction

    localparam vec_arr_t VEC = build_vec();

    logic       clk = 1'b0;
    logic       prog_n = 1'b0;
    logic [2:0] mode = 3'b010;
    logic       cs_a = 1'b1;
    logic [7:0] bus = 8'h00;
    logic [7:0] fb_a, fb_b;
    logic       fv_a, fv_b, ch_a, ch_b, in_a, in_b, dn_a, dn_b;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bytecfg_loader #(.FRAME_BYTES(FB), .NUM_FRAMES(NF), .STARTUP_CYCLES(SU)) dut_i (
        .cfg_clk(clk), .prog_n(prog_n), .mode_sel(mode), .cs_in(cs_a), .data_in(bus),
        .frame_byte(fb_a), .frame_valid(fv_a), .chain_out(ch_a), .init_n(in_a), .done(dn_a)
    );

    bytecfg_loader #(.FRAME_BYTES(FB), .NUM_FRAMES(NF), .STARTUP_CYCLES(SU)) dut_b (
        .cfg_clk(clk), .prog_n(prog_n), .mode_sel(mode), .cs_in(ch_a), .data_in(bus),
        .frame_byte(fb_b), .frame_valid(fv_b), .chain_out(ch_b), .init_n(in_b), .done(dn_b)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        bus = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        prog_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R9", "chain_out in reset", int'(ch_a), 1);
        chk("R9", "init_n in reset", int'(in_a), 1);
        chk("R9", "done in reset", int'(dn_a), 0);
        chk("R9", "frame_valid in reset", int'(fv_a), 0);
        @(posedge clk);
        #1;
        prog_n = 1'b1;
    endtask

    task automatic send_header();
        push(8'h00);
        for (int i = 0; i < 7; i++) push(hdr_val(i));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // main table: two loaders sharing one bus (R2 R4 R5 R7 R8)
        mode = 3'b010;
        cs_a = 1'b1;
        do_reset();
        for (int e = 0; e < NV; e++) begin
            push(VEC[e][13:6]);
            chk("R4", $sformatf("chain_a edge %0d", e), int'(ch_a), int'(VEC[e][5]));
            chk("R4", $sformatf("chain_b edge %0d", e), int'(ch_b), int'(VEC[e][4]));
            chk("R8", $sformatf("done_a edge %0d", e), int'(dn_a), int'(VEC[e][3]));
            chk("R8", $sformatf("done_b edge %0d", e), int'(dn_b), int'(VEC[e][2]));
            chk("R5", $sformatf("valid_a edge %0d", e), int'(fv_a), int'(VEC[e][1]));
            chk("R5", $sformatf("valid_b edge %0d", e), int'(fv_b), int'(VEC[e][0]));
            if (VEC[e][1]) chk("R5", "frame_byte a", int'(fb_a), int'(VEC[e][13:6]));
            if (VEC[e][0]) chk("R5", "frame_byte b", int'(fb_b), int'(VEC[e][13:6]));
        end
        // R7: later bytes ignored, no error
        for (int i = 0; i < 5; i++) push(8'h00);
        chk("R7", "init_a after full", int'(in_a), 1);
        chk("R7", "init_b after full", int'(in_b), 1);
        chk("R7", "done_b kept", int'(dn_b), 1);
        chk("R7", "no valid after full", int'(fv_a | fv_b), 0);

        // R2: header taken with cs low; R5: cs gating; R6: bad check byte
        do_reset();
        cs_a = 1'b0;
        send_header();
        chk("R2", "chain low after header with cs low", int'(ch_a), 0);
        for (int i = 0; i < 3; i++) begin
            push(8'h12);
            chk("R5", "no valid while deselected", int'(fv_a), 0);
            chk("R5", "no error while deselected", int'(in_a), 1);
        end
        cs_a = 1'b1;
        push(8'h7F);
        push(8'h5A);
        chk("R5", "valid after select", int'(fv_a), 1);
        chk("R5", "byte after select", int'(fb_a), 8'h5A);
        for (int i = 0; i < FB - 1; i++) push(8'h33);
        push(8'h00);
        chk("R6", "init low on bad check", int'(in_a), 0);
        for (int i = 0; i < 12; i++) push(frame_val(i, 0));
        chk("R6", "init stays low", int'(in_a), 0);
        chk("R6", "no valid in error", int'(fv_a), 0);
        chk("R6", "no done in error", int'(dn_a), 0);
        do_reset();
        chk("R9", "init back high after program", int'(in_a), 1);

        // R1: mode gate
        mode = 3'b000;
        send_header();
        chk("R1", "chain high with wrong mode", int'(ch_a), 1);
        chk("R1", "init high with wrong mode", int'(in_a), 1);
        mode = 3'b010;
        send_header();
        chk("R1", "chain low once mode selected", int'(ch_a), 0);

        // R6: bad start byte
        push(8'h7E);
        chk("R6", "init low on bad start", int'(in_a), 0);

        // R3: bad preamble
        do_reset();
        push(8'h00);
        push(8'hFF);
        push(8'hFF);
        chk("R3", "init high before preamble", int'(in_a), 1);
        push(8'h4E);
        chk("R3", "init low on bad preamble", int'(in_a), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule